// File: doc/BRIEF.md
# Serial Programming Host Sequencer

This block is the host side of a four-wire serial programming link to a flash microcontroller target. It owns the target's reset line and the serial clock and data-out pins, and it reads the target's serial data-out pin. A single `start` pulse runs one full programming pass. The block first holds the target in reset with the clock low and applies one reset pulse. It then waits a settle time and sends the four-byte enable command. It checks that the target echoed the enable key, and retries with a fresh reset pulse when it did not. After that it loads and commits a fixed number of flash pages.

Page data comes from a simple combinational lookup. The block presents a word address and expects the matching 16-bit word on `word_data` in the same cycle. Each word goes out as two load frames, the low byte first. Each page ends with a write-page frame. The block then either polls the target's busy flag or waits a fixed time, as `poll_en` selected at start. All delays are parameters counted in core clock cycles.

Top module: `serprog_host`

## Requirements
- R1: After reset and while idle, `tgt_rst` is high, `tgt_sck` and `tgt_mosi` are low, and `busy`, `done` and `err` are low. A reset applied in the middle of a pass returns the block to this state.
- R2: On `start`, `tgt_rst` goes low with `tgt_sck` low. It is then pulsed high for at least TRST_MIN+2 cycles and taken low again. At least SETTLE cycles pass from that falling edge to the first SCK rise. `tgt_sck` stays low during this whole preparation.
- R3: Every frame is 32 bits, sent most significant bit first. Each SCK high phase lasts exactly SCK_HALF cycles. MOSI only changes while SCK is low, and MISO is sampled on the SCK rising edge.
- R4: The enable frame is bytes 0xAC, 0x53, 0x00, 0x00, and all four bytes are sent even when the echo is wrong. SCK only toggles while `tgt_rst` is low.
- R5: If the byte received while the third byte is sent (bits 15:8 of the received word) is not 0x53, the block pulses `tgt_rst` high again, waits SETTLE cycles and resends the enable frame.
- R6: After MAX_RETRY retries, a further failed echo sets `err` and returns the block to idle with `tgt_rst` high, and no page frames are sent. `err` stays high until the next accepted `start`.
- R7: For each word, in ascending word order, the block sends a load-low frame 0x40, 0x00, idx, data[7:0] and then a load-high frame 0x48, 0x00, idx, data[15:8]. Here idx is the word index within the page, in the low WORD_BITS bits of the third byte.
- R8: While a page is loaded, `word_addr` equals page×2^WORD_BITS + idx. The data sent for that word is the `word_data` value presented for that address.
- R9: Each page ends with a commit frame 0x4C, addr[15:8], addr[7:0], 0x00, where addr is the word address of the page's first word.
- R10: In polling mode, after each commit the block sends 0xF0, 0x00, 0x00, 0x00 frames. It repeats them while bit 0 of the last received byte is 1, and moves on after the first response with bit 0 equal to 0.
- R11: In wait mode no poll frames are sent. At least PAGE_WAIT cycles separate the last SCK rise of a commit frame from the next frame or from `done`.
- R12: After the last of NUM_PAGES commits completes, `done` pulses for exactly one cycle and the block returns to idle with `tgt_rst` high.
- R13: `start` has no effect while a pass is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one programming pass (ignored while busy) |
| poll_en | input | 1 | 1: busy polling after each commit; 0: fixed wait; sampled at start |
| word_addr | output | PAGE_BITS+WORD_BITS | Word address whose data is requested |
| word_data | input | 16 | Flash word for `word_addr`, valid in the same cycle |
| tgt_sck | output | 1 | Serial clock to target |
| tgt_mosi | output | 1 | Serial data to target |
| tgt_miso | input | 1 | Serial data from target |
| tgt_rst | output | 1 | Target reset line level |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse after the last page completes |
| err | output | 1 | Enable handshake failed after all retries |

## Verification
The hardest paths to reach are the retry loop and busy polling. The retry loop needs the target to miss the echo a chosen number of times, up to and beyond the retry limit. Busy polling needs the target to report busy for a chosen number of polls after each commit. The bench drives these with a behavioural target model. The model shifts in each frame on SCK rises and returns the previous byte as the echo. A per-scenario count lets it corrupt the echo on the first few enable attempts and answer busy to a set number of poll frames. A table of scenarios walks these counts in both commit modes. Every frame is logged with its timing, so reset pulses, settle gaps and page-wait gaps are measured at the pins.

// File: rtl/sph_pkg.sv
package sph_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PWR, S_PULSE, S_SETTLE, S_EN,
    S_LLO, S_LHI, S_COMMIT, S_POLL, S_WAIT, S_NEXT
  } seq_st_t;

  localparam logic [7:0] OP_ENABLE = 8'hAC;
  localparam logic [7:0] EN_KEY    = 8'h53;
  localparam logic [7:0] OP_LD_LO  = 8'h40;
  localparam logic [7:0] OP_LD_HI  = 8'h48;
  localparam logic [7:0] OP_COMMIT = 8'h4C;
  localparam logic [7:0] OP_POLL   = 8'hF0;

  function automatic logic [31:0] mk_frame(input logic [7:0] b0, input logic [7:0] b1,
                                           input logic [7:0] b2, input logic [7:0] b3);
    return {b0, b1, b2, b3};
  endfunction

  // echo of the key arrives while the third byte is shifted out
  function automatic logic echo_ok(input logic [31:0] rx);
    return rx[15:8] == EN_KEY;
  endfunction

  function automatic logic target_busy(input logic [31:0] rx);
    return rx[0];
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int unsigned rst_pulse_len(input int unsigned trst_min);
    return trst_min + 2;
  endfunction

endpackage

// File: rtl/sph_delay.sv
module sph_delay #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] val,
  output logic          zero
);
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sph_shifter.sv
module sph_shifter #(
  parameter int SCK_HALF = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [31:0] tx,
  input  logic        miso,
  output logic        sck,
  output logic        mosi,
  output logic        busy,
  output logic        done,
  output logic [31:0] rx
);
  localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

  logic          busy_q, sck_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [4:0]    bit_q;
  logic [31:0]   tx_q, rx_q;
  logic          phase_end;

  assign phase_end = (cnt_q == CW'(SCK_HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sck_q <= 1'b0; done_q <= 1'b0;
      cnt_q  <= '0;   bit_q <= '0;   tx_q   <= '0; rx_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (go) begin
          busy_q <= 1'b1;
          tx_q   <= tx;
          cnt_q  <= '0;
          bit_q  <= '0;
          sck_q  <= 1'b0;
        end
      end else if (phase_end) begin
        cnt_q <= '0;
        if (!sck_q) begin
          sck_q <= 1'b1;
          rx_q  <= {rx_q[30:0], miso};
        end else begin
          sck_q <= 1'b0;
          if (bit_q == 5'd31) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 5'd1;
            tx_q  <= {tx_q[30:0], 1'b0};
          end
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sck  = sck_q;
  assign mosi = busy_q & tx_q[31];
  assign busy = busy_q;
  assign done = done_q;
  assign rx   = rx_q;

  assert_mosi_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |-> $stable(mosi));
  assert_go_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy_q);
  assert_done_ends_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q && !sck_q);
endmodule

// File: rtl/sph_seq.sv
module sph_seq
  import sph_pkg::*;
#(
  parameter int WORD_BITS = 5,
  parameter int PAGE_BITS = 6,
  parameter int NUM_PAGES = 2,
  parameter int MAX_RETRY = 3,
  parameter int SETTLE    = 100,
  parameter int RST_PULSE = 10,
  parameter int PAGE_WAIT = 100,
  parameter int DW        = 8,
  localparam int AW       = PAGE_BITS + WORD_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          poll_en,
  input  logic [15:0]   word_data,
  output logic [AW-1:0] word_addr,
  output logic          fr_go,
  output logic [31:0]   fr_tx,
  input  logic          fr_busy,
  input  logic          fr_done,
  input  logic [31:0]   fr_rx,
  output logic          dly_load,
  output logic [DW-1:0] dly_val,
  input  logic          dly_zero,
  output logic          tgt_rst,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          prep_phase
);
  localparam int RW = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;

  seq_st_t              st_q;
  logic [PAGE_BITS-1:0] page_q;
  logic [WORD_BITS-1:0] word_q;
  logic [RW-1:0]        retry_q;
  logic [15:0]          wlat_q;
  logic                 poll_q, sent_q, done_q, err_q, rst_q;
  logic                 frame_st, last_word, last_page, retry_out;
  logic [15:0]          page_base;
  logic [7:0]           idx8;

  assign frame_st  = (st_q == S_EN) || (st_q == S_LLO) || (st_q == S_LHI) ||
                     (st_q == S_COMMIT) || (st_q == S_POLL);
  assign last_word = (word_q == WORD_BITS'((1 << WORD_BITS) - 1));
  assign last_page = (page_q == PAGE_BITS'(NUM_PAGES - 1));
  assign retry_out = (retry_q == RW'(MAX_RETRY));
  assign page_base = 16'({page_q, {WORD_BITS{1'b0}}});
  assign idx8      = 8'(word_q);
  assign word_addr = {page_q, word_q};

  always_comb begin
    unique case (st_q)
      S_EN:     fr_tx = mk_frame(OP_ENABLE, EN_KEY, 8'h00, 8'h00);
      S_LLO:    fr_tx = mk_frame(OP_LD_LO, 8'h00, idx8, word_data[7:0]);
      S_LHI:    fr_tx = mk_frame(OP_LD_HI, 8'h00, idx8, wlat_q[15:8]);
      S_COMMIT: fr_tx = mk_frame(OP_COMMIT, page_base[15:8], page_base[7:0], 8'h00);
      S_POLL:   fr_tx = mk_frame(OP_POLL, 8'h00, 8'h00, 8'h00);
      default:  fr_tx = '0;
    endcase
    fr_go = frame_st && !sent_q && !fr_busy;
  end

  always_comb begin
    dly_load = 1'b0;
    dly_val  = '0;
    unique case (st_q)
      S_IDLE:   if (start)    begin dly_load = 1'b1; dly_val = DW'(RST_PULSE); end
      S_PWR:    if (dly_zero) begin dly_load = 1'b1; dly_val = DW'(RST_PULSE); end
      S_PULSE:  if (dly_zero) begin dly_load = 1'b1; dly_val = DW'(SETTLE);    end
      S_EN:     if (fr_done && !echo_ok(fr_rx) && !retry_out) begin
                  dly_load = 1'b1; dly_val = DW'(RST_PULSE);
                end
      S_COMMIT: if (fr_done && !poll_q) begin dly_load = 1'b1; dly_val = DW'(PAGE_WAIT); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE; page_q <= '0; word_q <= '0; retry_q <= '0;
      wlat_q <= '0;     poll_q <= 1'b0; sent_q <= 1'b0;
      done_q <= 1'b0;   err_q  <= 1'b0; rst_q  <= 1'b1;
    end else begin
      done_q <= 1'b0;
      if (fr_go) sent_q <= 1'b1;
      unique case (st_q)
        S_IDLE: if (start) begin
          st_q <= S_PWR; err_q <= 1'b0; retry_q <= '0;
          page_q <= '0; word_q <= '0; poll_q <= poll_en; rst_q <= 1'b0;
        end
        S_PWR:    if (dly_zero) begin st_q <= S_PULSE;  rst_q <= 1'b1; end
        S_PULSE:  if (dly_zero) begin st_q <= S_SETTLE; rst_q <= 1'b0; end
        S_SETTLE: if (dly_zero) st_q <= S_EN;
        S_EN: if (fr_done) begin
          sent_q <= 1'b0;
          if (echo_ok(fr_rx)) st_q <= S_LLO;
          else if (retry_out) begin st_q <= S_IDLE; err_q <= 1'b1; rst_q <= 1'b1; end
          else begin retry_q <= retry_q + 1'b1; st_q <= S_PULSE; rst_q <= 1'b1; end
        end
        S_LLO: begin
          if (fr_go) wlat_q <= word_data;
          if (fr_done) begin sent_q <= 1'b0; st_q <= S_LHI; end
        end
        S_LHI: if (fr_done) begin
          sent_q <= 1'b0;
          if (last_word) st_q <= S_COMMIT;
          else begin word_q <= word_q + 1'b1; st_q <= S_LLO; end
        end
        S_COMMIT: if (fr_done) begin
          sent_q <= 1'b0;
          st_q   <= poll_q ? S_POLL : S_WAIT;
        end
        S_POLL: if (fr_done) begin
          sent_q <= 1'b0;
          if (!target_busy(fr_rx)) st_q <= S_NEXT;
        end
        S_WAIT: if (dly_zero) st_q <= S_NEXT;
        S_NEXT: begin
          if (last_page) begin done_q <= 1'b1; st_q <= S_IDLE; rst_q <= 1'b1; end
          else begin page_q <= page_q + 1'b1; word_q <= '0; st_q <= S_LLO; end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign tgt_rst    = rst_q;
  assign busy       = (st_q != S_IDLE);
  assign done       = done_q;
  assign err        = err_q;
  assign prep_phase = (st_q == S_PWR) || (st_q == S_PULSE) || (st_q == S_SETTLE);

  assert_retry_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    retry_q <= RW'(MAX_RETRY));
  assert_err_goes_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> !busy && rst_q);
  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> rst_q);
  assert_poll_mode_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_POLL) |-> poll_q);
  assert_start_ignored_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && st_q != S_NEXT && st_q != S_EN) |=> busy && st_q != S_PWR);
endmodule

// File: rtl/serprog_host.sv
module serprog_host
  import sph_pkg::*;
#(
  parameter int SCK_HALF  = 4,
  parameter int WORD_BITS = 5,
  parameter int PAGE_BITS = 6,
  parameter int NUM_PAGES = 2,
  parameter int MAX_RETRY = 3,
  parameter int SETTLE    = 5000000,
  parameter int TRST_MIN  = 625,
  parameter int PAGE_WAIT = 1125000,
  localparam int AW       = PAGE_BITS + WORD_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          poll_en,
  output logic [AW-1:0] word_addr,
  input  logic [15:0]   word_data,
  output logic          tgt_sck,
  output logic          tgt_mosi,
  input  logic          tgt_miso,
  output logic          tgt_rst,
  output logic          busy,
  output logic          done,
  output logic          err
);
  localparam int RST_PULSE = int'(rst_pulse_len(TRST_MIN));
  localparam int DW = $clog2(max3(SETTLE, RST_PULSE, PAGE_WAIT) + 1);

  logic          fr_go, fr_busy, fr_done;
  logic [31:0]   fr_tx, fr_rx;
  logic          dly_load, dly_zero, prep_phase;
  logic [DW-1:0] dly_val;

  sph_shifter #(.SCK_HALF(SCK_HALF)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(fr_go), .tx(fr_tx), .miso(tgt_miso),
    .sck(tgt_sck), .mosi(tgt_mosi), .busy(fr_busy), .done(fr_done), .rx(fr_rx)
  );

  sph_delay #(.DW(DW)) u_delay (
    .clk(clk), .rst_n(rst_n), .load(dly_load), .val(dly_val), .zero(dly_zero)
  );

  sph_seq #(
    .WORD_BITS(WORD_BITS), .PAGE_BITS(PAGE_BITS), .NUM_PAGES(NUM_PAGES),
    .MAX_RETRY(MAX_RETRY), .SETTLE(SETTLE), .RST_PULSE(RST_PULSE),
    .PAGE_WAIT(PAGE_WAIT), .DW(DW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .poll_en(poll_en),
    .word_data(word_data), .word_addr(word_addr),
    .fr_go(fr_go), .fr_tx(fr_tx), .fr_busy(fr_busy), .fr_done(fr_done), .fr_rx(fr_rx),
    .dly_load(dly_load), .dly_val(dly_val), .dly_zero(dly_zero),
    .tgt_rst(tgt_rst), .busy(busy), .done(done), .err(err), .prep_phase(prep_phase)
  );

  assert_sck_quiet_prep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prep_phase |-> !tgt_sck);
  assert_clock_held_in_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sck |-> !tgt_rst);
  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tgt_sck && !tgt_mosi);
endmodule

// File: tb/test_serprog_host.sv
module test_serprog_host;
  localparam int SCK_HALF = 3, WB = 2, PB = 3, NP = 2, MAXR = 2;
  localparam int SETTLE = 40, TRST_MIN = 4, PAGE_WAIT = 50;
  localparam int WPP = 1 << WB;
  // scenario: [11] poll, [10:8] echo failures, [7:4] busy answers per commit, [0] expected err
  localparam logic [11:0] VEC [0:4] = '{12'h000, 12'h820, 12'h900, 12'h200, 12'hB11};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, poll_en = 1'b0, miso = 1'b0;
  logic [PB+WB-1:0] word_addr;
  logic [15:0] word_data;
  logic tgt_sck, tgt_mosi, tgt_rst, busy, done, err;

  always #2 clk = ~clk;

  function automatic logic [15:0] wd(input int a);
    return {8'(a * 13 + 33), 8'(a ^ 8'hC3)};
  endfunction
  assign word_data = wd(int'(word_addr));

  serprog_host #(.SCK_HALF(SCK_HALF), .WORD_BITS(WB), .PAGE_BITS(PB), .NUM_PAGES(NP),
    .MAX_RETRY(MAXR), .SETTLE(SETTLE), .TRST_MIN(TRST_MIN), .PAGE_WAIT(PAGE_WAIT))
  i_serprog_host (.clk(clk), .rst_n(rst_n), .start(start), .poll_en(poll_en),
    .word_addr(word_addr), .word_data(word_data), .tgt_sck(tgt_sck), .tgt_mosi(tgt_mosi),
    .tgt_miso(miso), .tgt_rst(tgt_rst), .busy(busy), .done(done), .err(err));

  int n_chk = 0, n_fail = 0;
  bit fin = 0;
  int scn_tag = 0, cfg_fails = 0, cfg_busy = 0;

  // target model state, owned by the monitor
  int seen_tag = 0, cyc = 0, nlog = 0, bitn = 0, fails_left = 0, busy_left = 0;
  int pulses = 0, pw_min = 0, hi_min = 0, hi_max = 0, done_cnt = 0, done_cyc = 0;
  int rst_rise = 0, last_fall = 0, rise_cyc = 0, fstart_v = 0;
  bit rise_seen = 0;
  logic rst_q = 1'b1, sck_q = 1'b0;
  logic [31:0] fr = '0;
  logic [7:0] osh = '0, resp;
  logic [31:0] flog [0:127];
  int fst [0:127], fen [0:127], fset [0:127];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (seen_tag != scn_tag) begin
      seen_tag = scn_tag; nlog = 0; pulses = 0; rise_seen = 0; pw_min = 1 << 30;
      hi_min = 1 << 30; hi_max = 0; done_cnt = 0; fails_left = cfg_fails; busy_left = 0;
    end
    if (done) begin done_cnt = done_cnt + 1; done_cyc = cyc; end
    if (tgt_rst && !rst_q) begin rst_rise = cyc; rise_seen = 1; end
    if (!tgt_rst && rst_q) begin
      if (rise_seen) begin
        pulses = pulses + 1;
        if (cyc - rst_rise < pw_min) pw_min = cyc - rst_rise;
      end
      last_fall = cyc;
    end
    if (tgt_rst) bitn = 0;
    else if (tgt_sck && !sck_q) begin
      if (bitn == 0) fstart_v = cyc;
      fr = {fr[30:0], tgt_mosi};
      bitn = bitn + 1;
      rise_cyc = cyc;
      if (bitn == 32) begin
        if (nlog < 128) begin
          flog[nlog] = fr; fst[nlog] = fstart_v; fen[nlog] = cyc; fset[nlog] = fstart_v - last_fall;
        end
        nlog = nlog + 1;
        bitn = 0;
        if (fr[31:24] == 8'hAC && fails_left > 0) fails_left = fails_left - 1;
        if (fr[31:24] == 8'h4C) busy_left = cfg_busy;
        if (fr[31:24] == 8'hF0 && busy_left > 0) busy_left = busy_left - 1;
      end
    end else if (!tgt_sck && sck_q) begin
      if (cyc - rise_cyc < hi_min) hi_min = cyc - rise_cyc;
      if (cyc - rise_cyc > hi_max) hi_max = cyc - rise_cyc;
      if (bitn == 8 || bitn == 16 || bitn == 24) begin
        if (bitn == 16) resp = (fr[15:8] == 8'hAC && fails_left > 0) ? 8'h00 : fr[7:0];
        else if (bitn == 24 && fr[23:16] == 8'hF0) resp = {7'b0, 1'(busy_left > 0)};
        else resp = 8'h00;
        miso = resp[7];
        osh = {resp[6:0], 1'b0};
      end else begin
        miso = osh[7];
        osh = {osh[6:0], 1'b0};
      end
    end
    rst_q = tgt_rst;
    sck_q = tgt_sck;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string frame_req(input logic [7:0] op);
    case (op)
      8'hAC: return "R4 enable frame";
      8'h40: return "R7 R8 load-low frame";
      8'h48: return "R7 R8 load-high frame";
      8'h4C: return "R9 commit frame";
      8'hF0: return "R10 poll frame";
      default: return "R7 frame";
    endcase
  endfunction

  task automatic run_scn(input logic [11:0] v);
    logic [31:0] exp [0:127];
    int cidx [0:NP-1];
    int k, en, retries;
    bit poll, xerr;
    int fails, bz;
    poll = v[11]; fails = int'(v[10:8]); bz = int'(v[7:4]); xerr = v[0];
    cfg_fails = fails; cfg_busy = bz; scn_tag = scn_tag + 1;
    poll_en = poll;
    repeat (2) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk(busy && !err, "R6 err cleared by start", {30'b0, busy, err}, 32'h2);
    repeat (300) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;   // R13: must be ignored
    while (busy) @(negedge clk);
    repeat (5) @(negedge clk);
    // expected frames from the requirements
    retries = xerr ? MAXR : fails;
    en = retries + 1;
    k = 0;
    for (int e = 0; e < en; e++) begin exp[k] = 32'hAC530000; k++; end
    if (!xerr) begin
      for (int p = 0; p < NP; p++) begin
        for (int w = 0; w < WPP; w++) begin
          exp[k] = {8'h40, 8'h00, 8'(w), wd(p * WPP + w)[7:0]}; k++;
          exp[k] = {8'h48, 8'h00, 8'(w), wd(p * WPP + w)[15:8]}; k++;
        end
        exp[k] = {8'h4C, 16'(p * WPP), 8'h00}; cidx[p] = k; k++;
        if (poll) for (int b = 0; b <= bz; b++) begin exp[k] = 32'hF0000000; k++; end
      end
    end
    chk(nlog == k, "R12 R13 frame count", 32'(nlog), 32'(k));
    for (int i = 0; i < k && i < nlog; i++)
      chk(flog[i] == exp[i], frame_req(exp[i][31:24]), flog[i], exp[i]);
    chk(err == xerr, "R6 err flag", {31'b0, err}, {31'b0, xerr});
    chk(done_cnt == (xerr ? 0 : 1), "R12 done pulses", 32'(done_cnt), xerr ? 0 : 1);
    chk(tgt_rst && !busy, "R12 R6 idle with reset released", {30'b0, tgt_rst, busy}, 32'h2);
    chk(pulses == en, "R5 reset pulse count", 32'(pulses), 32'(en));
    chk(pw_min >= TRST_MIN + 2, "R2 reset pulse width", 32'(pw_min), TRST_MIN + 2);
    for (int e = 0; e < en && e < nlog; e++)
      chk(fset[e] >= SETTLE, "R2 R5 settle before enable", 32'(fset[e]), SETTLE);
    chk(hi_min == SCK_HALF && hi_max == SCK_HALF, "R3 SCK high phase",
        32'(hi_max), SCK_HALF);
    if (!poll && !xerr && nlog == k) begin
      chk(fst[cidx[0] + 1] - fen[cidx[0]] >= PAGE_WAIT, "R11 wait before next page",
          32'(fst[cidx[0] + 1] - fen[cidx[0]]), PAGE_WAIT);
      chk(done_cyc - fen[cidx[NP-1]] >= PAGE_WAIT, "R11 wait before done",
          32'(done_cyc - fen[cidx[NP-1]]), PAGE_WAIT);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!fin) begin
      n_chk = n_chk + 1; n_fail = n_fail + 1;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(tgt_rst && !tgt_sck && !tgt_mosi && !busy && !done && !err, "R1 state in reset",
        {26'b0, tgt_rst, tgt_sck, tgt_mosi, busy, done, err}, 32'h20);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(tgt_rst && !tgt_sck && !tgt_mosi && !busy && !done && !err, "R1 idle after reset",
        {26'b0, tgt_rst, tgt_sck, tgt_mosi, busy, done, err}, 32'h20);
    for (int i = 0; i < 5; i++) run_scn(VEC[i]);
    // R6: err sticky while idle after the failing scenario
    repeat (20) @(negedge clk);
    chk(err && tgt_rst && !busy, "R6 err held in idle", {29'b0, err, tgt_rst, busy}, 32'h6);
    run_scn(VEC[0]);
    // R1: reset in the middle of a pass
    poll_en = 1'b0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (400) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(tgt_rst && !tgt_sck && !tgt_mosi && !busy && !err, "R1 mid-pass reset",
        {27'b0, tgt_rst, tgt_sck, tgt_mosi, busy, err}, 32'h10);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(tgt_rst && !busy && !done, "R1 idle after mid-pass reset",
        {29'b0, tgt_rst, busy, done}, 32'h4);
    fin = 1;
    summary();
    $finish;
  end
endmodule